// File: doc/BRIEF.md
# Triggered Parallel-to-Serial Transfer Engine

This block is a serial master that sends one frame each time a hardware trigger line makes its programmed edge. The frame comes from one of two places. The first is the state of a parallel input bus, captured in the same cycle that the trigger edge is recognised. The second is an alternate data register that software loads. The frame is sent MSB first on a serial data line. A serial clock runs at an even fraction of the system clock and rests low between transfers.

A single configuration word sets the following: trigger polarity, data source, frame length, clock divider, a multiple-transfer mode with its own clock-cycle count, and a timed-bus mode that allows frames of up to 32 bits. The block checks whether the multiple-transfer count is long enough to carry the frame. If it is not, the block raises an error and ignores triggers. A trigger that arrives during a transfer is dropped and is recorded in a sticky overrun flag.

Top module: `tps_top`

## Requirements
- R1: Configuration bit 0 selects the trigger edge: 1 means a rising edge of `trig_i` starts a transfer and 0 means a falling edge does. The opposite edge starts nothing.
- R2: Configuration bit 1 selects the data source. With 0, the frame is the value of `pins_i` captured at the accepted trigger edge, and later changes on `pins_i` do not affect it. With 1, the frame is the alternate data register loaded through `alt_we_i`.
- R3: Data leaves MSB first on `sdo_o` and changes only on the falling edges of `sck_o`. The first bit is valid before the first rising edge. `sck_o` and `sdo_o` are low while idle.
- R4: The `sck_o` period is 2*(div+1) system clocks, where div is configuration bits [18:15].
- R5: The frame length is configuration bits [14:10] plus 1. When timed-bus mode is off, the length is limited to 16 bits.
- R6: When configuration bit 2 (multiple-transfer) is set and timed-bus mode is off, the transfer has count+1 `sck_o` cycles, where count is bits [9:4]. Bits sent after the frame are zero.
- R7: When multiple-transfer mode is on, timed-bus mode is off and count+1 is less than the frame length, `cfg_err_o` is high and triggers start nothing.
- R8: When configuration bit 3 (timed-bus) is set, the count field and the multiple-transfer bit are ignored. The transfer has exactly as many clock cycles as the frame length, up to 32.
- R9: Every configuration bit resets to zero. Bits [31:19] always read as zero on `cfg_o`.
- R10: `busy_o` is high during a transfer. At the end of a transfer, `done_o` is high for exactly one cycle, and `busy_o` is low in that same cycle.
- R11: A trigger edge while `busy_o` is high is ignored and sets `ovr_o`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Configuration readback |
| alt_we_i | input | 1 | Alternate data write strobe |
| alt_wdata_i | input | 32 | Alternate data write value |
| pins_i | input | 32 | Parallel input bus |
| trig_i | input | 1 | Asynchronous hardware trigger |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ovr_o | output | 1 | Sticky trigger overrun |
| cfg_err_o | output | 1 | Count shorter than frame |

## Verification
A bad bit counter or a bad latched count shows up as the wrong number of `sck_o` rising edges before `done_o`. A bad shift register or bad source selection shows up as wrong bits sampled at those rising edges. Both errors are visible within one transfer. A bad divider state changes the spacing between rising edges, starting from the second one. An error in the edge detector or in the error gate shows up within a few cycles of a trigger, either as `busy_o` failing to rise or as `busy_o` rising when it must stay low.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int DATA_W   = 32;
  localparam int FSZ_W    = 5;
  localparam int CNT_W    = 6;
  localparam int DIV_W    = 4;
  localparam int BASE_MAX = 16;
  localparam int LEN_W    = $clog2(DATA_W) + 1;
  localparam int NSCK_W   = CNT_W + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [FSZ_W-1:0] fsz;
    logic [CNT_W-1:0] mt_cnt;
    logic             tb_en;
    logic             mt_en;
    logic             src_alt;
    logic             pol;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);
endpackage

// File: rtl/tps_trig_edge.sv
module tps_trig_edge #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], trig_i};
  end

  // sh_q[SYNC-1] is synchronized level, sh_q[SYNC] its previous value
  assign edge_o = pol_i ? (sh_q[SYNC-1] & ~sh_q[SYNC])
                        : (~sh_q[SYNC-1] & sh_q[SYNC]);
endmodule

// File: rtl/tps_sck_gen.sv
module tps_sck_gen
  import tps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NSCK_W-1:0] nsck_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              fall_o,
  output logic              done_o
);
  logic              busy_q, sck_q, done_q;
  logic [DIV_W-1:0]  hcnt_q, div_q;
  logic [NSCK_W-1:0] bit_q, n_q;
  logic              tick, last;

  assign tick   = busy_q && (hcnt_q == div_q);
  assign last   = (bit_q == n_q - NSCK_W'(1));
  assign fall_o = tick && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      n_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        hcnt_q <= '0;
        bit_q  <= '0;
        div_q  <= div_i;
        n_q    <= nsck_i;
      end else if (tick) begin
        hcnt_q <= '0;
        sck_q  <= ~sck_q;
        if (sck_q) begin
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + NSCK_W'(1);
          end
        end
      end else if (busy_q) begin
        hcnt_q <= hcnt_q + DIV_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign done_o = done_q;

  assert_sck_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/tps_shifter.sv
module tps_shifter
  import tps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  shamt_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i << shamt_i;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[DATA_W-1];
endmodule

// File: rtl/tps_top.sv
module tps_top
  import tps_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_o,
  input  logic        alt_we_i,
  input  logic [31:0] alt_wdata_i,
  input  logic [31:0] pins_i,
  input  logic        trig_i,
  output logic        sck_o,
  output logic        sdo_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        ovr_o,
  output logic        cfg_err_o
);
  cfg_t              cfg_q;
  logic [DATA_W-1:0] alt_q;
  logic              ovr_q;
  logic              trig_edge, accept, busy, sck, fall, msb;
  logic [LEN_W-1:0]  frame_raw, frame_len, shamt;
  logic [NSCK_W-1:0] mt_len, nsck;
  logic              cfg_err;
  logic [31-CFG_BITS:0] unused_wbits;

  assign unused_wbits = cfg_wdata_i[31:CFG_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      alt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i[CFG_BITS-1:0]);
      if (alt_we_i) alt_q <= alt_wdata_i;
      if (trig_edge && busy) ovr_q <= 1'b1;
    end
  end

  // frame length: timed-bus allows full width, otherwise capped
  assign frame_raw = LEN_W'(cfg_q.fsz) + LEN_W'(1);
  assign frame_len = (!cfg_q.tb_en && frame_raw > LEN_W'(BASE_MAX)) ? LEN_W'(BASE_MAX)
                                                                     : frame_raw;
  assign mt_len    = NSCK_W'(cfg_q.mt_cnt) + NSCK_W'(1);
  assign nsck      = (cfg_q.mt_en && !cfg_q.tb_en) ? mt_len : NSCK_W'(frame_len);
  assign cfg_err   = cfg_q.mt_en && !cfg_q.tb_en && (mt_len < NSCK_W'(frame_len));
  assign shamt     = LEN_W'(DATA_W) - frame_len;
  assign accept    = trig_edge && !busy && !cfg_err;

  tps_trig_edge #(.SYNC(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .pol_i  (cfg_q.pol),
    .edge_o (trig_edge)
  );

  tps_sck_gen u_sck (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .div_i   (cfg_q.div),
    .nsck_i  (nsck),
    .busy_o  (busy),
    .sck_o   (sck),
    .fall_o  (fall),
    .done_o  (done_o)
  );

  // shift register doubles as the serialization register for pin captures
  tps_shifter u_shf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  (cfg_q.src_alt ? alt_q : pins_i),
    .shamt_i (shamt),
    .shift_i (fall),
    .msb_o   (msb)
  );

  assign cfg_o     = {{(32-CFG_BITS){1'b0}}, cfg_q};
  assign sck_o     = sck;
  assign sdo_o     = busy & msb;
  assign busy_o    = busy;
  assign ovr_o     = ovr_q;
  assign cfg_err_o = cfg_err;

  assert_err_blocks_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cfg_err && !cfg_we_i) |=> !busy);
  assert_ovr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  assert_sdo_stable_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sck && $past(sck)) |-> $stable(sdo_o));
  assert_nsck_fits_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.tb_en |-> (nsck == NSCK_W'(frame_len) && !cfg_err));
endmodule

// File: tb/sim_tps_top.sv
`timescale 1ns/1ps
module sim_tps_top;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0, alt_we_i = 0, trig_i = 0;
  logic [31:0] cfg_wdata_i = 0, alt_wdata_i = 0, pins_i = 0;
  logic [31:0] cfg_o;
  logic        sck_o, sdo_o, busy_o, done_o, ovr_o, cfg_err_o;
  int          n_vec = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  tps_top u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit pol, input bit src, input bit mt, input bit tb,
                                     input int cnt, input int fsz, input int div);
    return {13'b0, div[3:0], fsz[4:0], cnt[5:0], tb, mt, src, pol};
  endfunction

  task automatic wcfg(input logic [31:0] v);
    @(negedge clk_i); cfg_we_i = 1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic walt(input logic [31:0] v);
    @(negedge clk_i); alt_we_i = 1; alt_wdata_i = v;
    @(negedge clk_i); alt_we_i = 0;
  endtask

  // move to idle level (inactive edge), then make the active edge
  task automatic fire(input bit pol);
    @(negedge clk_i); trig_i = ~pol;
    repeat (4) @(negedge clk_i);
    trig_i = pol;
  endtask

  // collect one transfer; checks bit count, bits, sck period, done pulse
  task automatic grab(input string req, input int n, input logic [63:0] exp, input int div);
    logic [63:0] got = 0;
    int rises = 0, dn = 0, last_rise = -1, t = 0, per_bad = 0, sdo_bad = 0;
    logic psck = 0, psdo = 0;
    bit busy_seen = 0;
    while (t < 4000 && dn == 0) begin
      @(negedge clk_i); t++;
      if (busy_o) busy_seen = 1;
      if (busy_seen && !psck && sck_o) begin
        got = {got[62:0], sdo_o};
        if (last_rise >= 0 && (t - last_rise) != 2 * (div + 1)) per_bad++;
        last_rise = t;
        rises++;
      end
      if (psck && sck_o && sdo_o !== psdo) sdo_bad++;
      if (done_o) begin
        dn = 1;
        chk({req, " R10 busy low at done"}, 64'(busy_o), 0);
      end
      psck = sck_o; psdo = sdo_o;
    end
    @(negedge clk_i);
    chk({req, " R10 done one cycle"}, 64'({done_o, dn[0]}), 64'b01);
    chk({req, " sck count"}, 64'(rises), 64'(n));
    chk({req, " bits"}, got, exp);
    chk({req, " R4 period"}, 64'(per_bad), 0);
    chk({req, " R3 sdo steady while sck high"}, 64'(sdo_bad), 0);
    chk({req, " R3 idle low"}, 64'({sck_o, sdo_o, busy_o}), 0);
  endtask

  task automatic t_reset;
    chk("R9 reset cfg", 64'(cfg_o), 0);
    chk("R10 reset outputs", 64'({sck_o, sdo_o, busy_o, done_o, ovr_o, cfg_err_o}), 0);
  endtask

  task automatic t_reserved;
    wcfg(32'hFFFF_FFFF);
    chk("R9 reserved read zero", 64'(cfg_o), 64'h7FFFF);
    wcfg(0);
  endtask

  task automatic t_rise_pins;
    wcfg(mk(1, 0, 0, 0, 0, 7, 1));
    pins_i = 32'hFFFF_FFA5;
    fire(1);
    fork
      grab("R1 R2 R5 rise/pins", 8, 64'hA5, 1);
      begin wait (busy_o); @(negedge clk_i); pins_i = 32'h0000_0000; end
    join
  endtask

  task automatic t_fall_pol;
    wcfg(mk(0, 0, 0, 0, 0, 7, 0));
    pins_i = 32'h3C;
    @(negedge clk_i); trig_i = 0;
    repeat (4) @(negedge clk_i);
    trig_i = 1;
    repeat (20) @(negedge clk_i);
    chk("R1 rising ignored with pol 0", 64'(busy_o), 0);
    trig_i = 0;
    grab("R1 falling pol", 8, 64'h3C, 0);
  endtask

  task automatic t_alt;
    walt(32'h0000_BEEF);
    wcfg(mk(1, 1, 0, 0, 0, 15, 3));
    pins_i = 32'h1234_5678;
    fire(1);
    grab("R2 R4 alt src", 16, 64'hBEEF, 3);
  endtask

  task automatic t_mt;
    wcfg(mk(1, 0, 1, 0, 11, 7, 0));
    chk("R6 no err", 64'(cfg_err_o), 0);
    pins_i = 32'h5A;
    fire(1);
    grab("R6 mt count", 12, 64'h5A0, 0);
  endtask

  task automatic t_err;
    wcfg(mk(1, 0, 1, 0, 3, 7, 0));
    chk("R7 err flagged", 64'(cfg_err_o), 1);
    fire(1);
    repeat (20) @(negedge clk_i);
    chk("R7 no start on err", 64'({busy_o, ovr_o}), 0);
  endtask

  task automatic t_tb;
    walt(32'hDEAD_BEEF);
    wcfg(mk(1, 1, 1, 1, 3, 31, 0));
    chk("R8 mt ignored no err", 64'(cfg_err_o), 0);
    fire(1);
    grab("R8 timed 32b", 32, 64'hDEAD_BEEF, 0);
  endtask

  task automatic t_clamp;
    walt(32'h1234_ABCD);
    wcfg(mk(1, 1, 0, 0, 0, 31, 0));
    fire(1);
    grab("R5 clamp 16", 16, 64'hABCD, 0);
  endtask

  task automatic t_ovr;
    walt(32'h0000_00C3);
    wcfg(mk(1, 1, 0, 0, 0, 7, 2));
    chk("R11 ovr clear before", 64'(ovr_o), 0);
    fire(1);
    fork
      grab("R11 single xfer", 8, 64'hC3, 2);
      begin wait (busy_o); fire(1); repeat (6) @(negedge clk_i);
            chk("R11 ovr set", 64'(ovr_o), 1); end
    join
    repeat (10) @(negedge clk_i);
    chk("R11 ovr sticky", 64'(ovr_o), 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reserved();
    t_rise_pins();
    t_fall_pol();
    t_alt();
    t_mt();
    t_err();
    t_tb();
    t_clamp();
    t_ovr();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule